// File: doc/BRIEF.md
# Zero-Allocating Direct-Mapped Data Cache

This block is a small write-back data cache with one direct-mapped way. It serves word loads and word stores, and it also serves a line-clearing operation. That operation sets all 32 bytes of the line holding the computed address to zero. Every request carries two operand values and a flag. When the flag is set, the first operand counts as a literal zero, so the address is the second operand alone. When the flag is clear, the address is the sum of the two operands.

A clearing request that hits wipes the resident line in place. A clearing request that misses claims the line and fills it with zeros. It never reads backing memory. If the slot it claims holds a modified line, that line is first written out through the line-wide memory port. Loads and stores that miss write back any dirty victim, then fetch the line and finish as hits.

A requester hands over one operation at a time through a valid/ready pair. Each operation ends with a one-cycle completion pulse, which carries read data for loads. No other result is produced.

Top module: `zcache`

## Requirements
- R1: The effective address is `req_rb` when `req_ra_zero` is 1, and `req_ra + req_rb` (modulo 2^ADDR_W) when it is 0. Byte offset is address bits [4:0], line index bits [7:5], tag the bits above.
- R2: A clearing operation (`req_op` = 2) on a resident line makes every word of that line read as zero, whatever the low five address bits are, with no memory transfer.
- R3: A clearing operation on a non-resident line whose slot is invalid or clean causes no memory transfer at all, and the line then reads as zero.
- R4: A clearing operation whose slot holds a dirty line of another tag first writes that victim (full 256-bit line, at its own line address) to memory, and issues no read.
- R5: A cleared line is left valid and dirty, so its later eviction writes 32 zero bytes to memory.
- R6: A load (`req_op` = 0 or 3) to any word of a cleared line returns zero with no memory access.
- R7: A load or store (`req_op` = 1) miss fetches the line with one read after any victim write-back. A store replaces the word selected by address bits [4:2], and a load returns that word.
- R8: `req_ready` is high only while idle and falls the cycle after a request is accepted. Each operation ends with `resp_valid` high for exactly one cycle, in which `req_ready` is high again.
- R9: After reset `req_ready` is 1, `resp_valid` and `mem_req` are 0, and every line is invalid, so the first load to any address misses.
- R10: Once `mem_req` is raised, it stays high with `mem_we`, `mem_addr` and `mem_wdata` unchanged until the cycle of `mem_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_op | input | 2 | 0/3 load, 1 store, 2 clear line |
| req_ra_zero | input | 1 | Treat first operand as zero |
| req_ra | input | ADDR_W | First operand (base) |
| req_rb | input | ADDR_W | Second operand (index) |
| req_wdata | input | WORD_W | Store data |
| resp_valid | output | 1 | Operation complete (one cycle) |
| resp_rdata | output | WORD_W | Load data; zero for other ops |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 write-back, 0 line read |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | LINE_BYTES*8 | Line written back |
| mem_rdata | input | LINE_BYTES*8 | Line returned by a read |
| mem_ack | input | 1 | Transfer done; read data valid |

## Verification
The clearing operation is driven in three slot situations: the line is resident, the slot is empty or holds a clean line, and the slot holds a dirty line of another tag. Counting memory reads and writes per operation separates these, since only the last may write and none may read. Offsets at the start, middle and end of a line, sums that carry into the index, and a set flag with a nonzero first operand show whether the whole line is cleared and whether the address adder and the zero-override are right. Loads after eviction and refill show that the zeros and the stored words really reached memory, and were not just held in the cache.

// File: rtl/zcache.sv
module zcache #(
  parameter int ADDR_W     = 32,
  parameter int LINES      = 8,
  parameter int WORD_W     = 32,
  parameter int LINE_BYTES = 32,
  localparam int LINE_W    = LINE_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic              req_ra_zero,
  input  logic [ADDR_W-1:0] req_ra,
  input  logic [ADDR_W-1:0] req_rb,
  input  logic [WORD_W-1:0] req_wdata,
  output logic              resp_valid,
  output logic [WORD_W-1:0] resp_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_W-1:0] mem_wdata,
  input  logic [LINE_W-1:0] mem_rdata,
  input  logic              mem_ack
);
  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int BSH   = $clog2(WORD_W / 8);
  localparam int WS_W  = OFF_W - BSH;

  localparam logic [1:0] OP_STORE = 2'd1;
  localparam logic [1:0] OP_ZERO  = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_CHK, S_WB, S_FILL} st_t;
  st_t st;

  logic [ADDR_W-BSH-1:0] ea_q;
  logic [1:0]            op_q;
  logic [WORD_W-1:0]     wd_q;
  logic [LINE_W-1:0]     data_q [LINES];
  logic [TAG_W-1:0]      tag_q  [LINES];
  logic [LINES-1:0]      vld_q, dty_q;

  logic [ADDR_W-1:0] ea_n;
  logic              unused_low;
  assign ea_n       = req_ra_zero ? req_rb : req_ra + req_rb;
  assign unused_low = ^ea_n[BSH-1:0];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [WS_W-1:0]  wsel;
  assign wsel = ea_q[WS_W-1:0];
  assign idx  = ea_q[WS_W +: IDX_W];
  assign tag  = ea_q[ADDR_W-BSH-1 -: TAG_W];

  logic hit, vic_dirty, is_zero, is_store;
  assign hit       = vld_q[idx] && (tag_q[idx] == tag);
  assign vic_dirty = vld_q[idx] && dty_q[idx];
  assign is_zero   = (op_q == OP_ZERO);
  assign is_store  = (op_q == OP_STORE);

  logic [LINE_W-1:0] line_cur, line_st;
  always_comb begin
    line_cur = data_q[idx];
    line_st  = line_cur;
    line_st[int'(wsel)*WORD_W +: WORD_W] = wd_q;
  end

  logic zero_alloc, fill_done;
  assign zero_alloc = (st == S_CHK) && is_zero && !hit && !vic_dirty;
  assign fill_done  = (st == S_FILL) && mem_ack;

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st == S_WB) || (st == S_FILL);
  assign mem_we    = (st == S_WB);
  assign mem_addr  = (st == S_WB) ? {tag_q[idx], idx, {OFF_W{1'b0}}}
                                  : {tag, idx, {OFF_W{1'b0}}};
  assign mem_wdata = line_cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      vld_q      <= '0;
      dty_q      <= '0;
      resp_valid <= 1'b0;
      resp_rdata <= '0;
      ea_q       <= '0;
      op_q       <= '0;
      wd_q       <= '0;
    end else begin
      resp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          ea_q <= ea_n[ADDR_W-1:BSH];
          op_q <= req_op;
          wd_q <= req_wdata;
          st   <= S_CHK;
        end
        S_CHK: begin
          if (hit) begin
            if (is_zero || is_store) dty_q[idx] <= 1'b1;
            resp_rdata <= (is_zero || is_store) ? '0
                        : line_cur[int'(wsel)*WORD_W +: WORD_W];
            resp_valid <= 1'b1;
            st         <= S_IDLE;
          end else if (vic_dirty) begin
            st <= S_WB;
          end else if (is_zero) begin
            vld_q[idx] <= 1'b1;
            dty_q[idx] <= 1'b1;
            resp_rdata <= '0;
            resp_valid <= 1'b1;
            st         <= S_IDLE;
          end else begin
            st <= S_FILL;
          end
        end
        S_WB: if (mem_ack) begin
          vld_q[idx] <= 1'b0;
          dty_q[idx] <= 1'b0;
          st         <= S_CHK;
        end
        S_FILL: if (mem_ack) begin
          vld_q[idx] <= 1'b1;
          dty_q[idx] <= 1'b0;
          st         <= S_CHK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if ((st == S_CHK) && is_zero && (hit || !vic_dirty))
      data_q[idx] <= '0;
    else if ((st == S_CHK) && hit && is_store)
      data_q[idx] <= line_st;
    else if (fill_done)
      data_q[idx] <= mem_rdata;
    if (zero_alloc || fill_done)
      tag_q[idx] <= tag;
  end
endmodule

// File: rtl/zcache_chk.sv
module zcache_chk #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [1:0]        op_q,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LINE_W-1:0] mem_wdata
);
  p_zero_no_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && op_q == 2'd2) |-> !(mem_req && !mem_we));

  p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_resp_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  p_resp_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> req_ready);

  p_idle_no_mem_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=>
      (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));
endmodule

bind zcache zcache_chk #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .op_q(op_q), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/sim_zcache.sv
`timescale 1ns/1ps
module sim_zcache;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [1:0]   req_op = 2'd0;
  logic         req_ra_zero = 1'b0;
  logic [31:0]  req_ra = '0, req_rb = '0, req_wdata = '0;
  logic         resp_valid;
  logic [31:0]  resp_rdata;
  logic         mem_req, mem_we;
  logic [31:0]  mem_addr;
  logic [255:0] mem_wdata;
  logic [255:0] mem_rdata = '0;
  logic         mem_ack = 1'b0;

  always #2.5 clk = ~clk;

  zcache u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_ra_zero(req_ra_zero), .req_ra(req_ra), .req_rb(req_rb),
    .req_wdata(req_wdata), .resp_valid(resp_valid), .resp_rdata(resp_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, hold_viol = 0, busy_viol = 0;
  int cyc = 0;
  logic [255:0] mem [256];
  logic         mem_init = 1'b0;
  int           wait_c = 0;
  logic [31:0]  hold_addr;
  logic         hold_we;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Memory model: answers on the third waiting cycle, counts transfers.
  always @(negedge clk) begin
    if (!mem_init) begin
      for (int i = 0; i < 256; i++)
        for (int w = 0; w < 8; w++)
          mem[i][w*32 +: 32] = 32'hA500_0000 | (i << 8) | w;
      mem_init = 1'b1;
    end
    if (!mem_req) begin
      mem_ack = 1'b0;
      wait_c  = 0;
    end else if (!mem_ack) begin
      if (wait_c > 0 && (mem_addr != hold_addr || mem_we != hold_we)) hold_viol++;
      hold_addr = mem_addr;
      hold_we   = mem_we;
      wait_c++;
      if (wait_c == 3) begin
        mem_ack = 1'b1;
        if (mem_we) begin
          mem[mem_addr[12:5]] = mem_wdata;
          wr_cnt++;
        end else begin
          mem_rdata = mem[mem_addr[12:5]];
          rd_cnt++;
        end
      end
    end else begin
      mem_ack = 1'b0;
    end
  end

  task automatic run_op(input logic [1:0] op, input logic raz, input logic [31:0] ra,
                        input logic [31:0] rb, input logic [31:0] wd,
                        output logic [31:0] rd, output int nrd, output int nwr);
    int r0, w0;
    r0 = rd_cnt;
    w0 = wr_cnt;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_ra_zero = raz;
    req_ra = ra; req_rb = rb; req_wdata = wd;
    @(posedge clk);
    #1 req_valid = 1'b0;
    do begin
      @(negedge clk);
      if (!resp_valid && req_ready) busy_viol++;
    end while (!resp_valid);
    rd  = resp_rdata;
    nrd = rd_cnt - r0;
    nwr = wr_cnt - w0;
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic        raz;
    logic [31:0] ra;
    logic [31:0] rb;
    logic [31:0] wd;
    logic [31:0] exp;
    logic [3:0]  nrd;
    logic [3:0]  nwr;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b1, 32'h0,    32'h40,  32'h0,        32'hA500_0200, 4'd1, 4'd0, 4'd7}, // R7 load miss fill
    '{2'd0, 1'b0, 32'h40,   32'h1C,  32'h0,        32'hA500_0207, 4'd0, 4'd0, 4'd1}, // R1 sum, last word
    '{2'd2, 1'b0, 32'h40,   32'h13,  32'h0,        32'h0,         4'd0, 4'd0, 4'd2}, // R2 clear on hit
    '{2'd0, 1'b1, 32'hFFFF, 32'h48,  32'h0,        32'h0,         4'd0, 4'd0, 4'd6}, // R6, R1 ra ignored
    '{2'd2, 1'b1, 32'h0,    32'h6F,  32'h0,        32'h0,         4'd0, 4'd0, 4'd3}, // R3 clear miss, invalid
    '{2'd0, 1'b1, 32'h0,    32'h74,  32'h0,        32'h0,         4'd0, 4'd0, 4'd6}, // R6 load zeroed line
    '{2'd1, 1'b1, 32'h0,    32'h88,  32'hDEADBEEF, 32'h0,         4'd1, 4'd0, 4'd7}, // R7 store miss
    '{2'd0, 1'b0, 32'h80,   32'h08,  32'h0,        32'hDEADBEEF,  4'd0, 4'd0, 4'd7}, // R7 load stored word
    '{2'd2, 1'b1, 32'h0,    32'h190, 32'h0,        32'h0,         4'd0, 4'd1, 4'd4}, // R4 dirty victim
    '{2'd0, 1'b1, 32'h0,    32'h80,  32'h0,        32'hA500_0400, 4'd1, 4'd1, 4'd5}, // R5 evict zero line
    '{2'd0, 1'b1, 32'h0,    32'h88,  32'h0,        32'hDEADBEEF,  4'd0, 4'd0, 4'd4}, // R4 victim reached mem
    '{2'd0, 1'b1, 32'h0,    32'h194, 32'h0,        32'h0,         4'd1, 4'd0, 4'd5}, // R5 zeros in memory
    '{2'd0, 1'b0, 32'hF0,   32'h10,  32'h0,        32'hA500_0800, 4'd1, 4'd0, 4'd1}, // R1 carry to index
    '{2'd2, 1'b0, 32'h40,   32'h40,  32'h0,        32'h0,         4'd0, 4'd0, 4'd3}, // R3 clean victim
    '{2'd0, 1'b1, 32'h0,    32'h84,  32'h0,        32'h0,         4'd0, 4'd0, 4'd6}, // R6
    '{2'd1, 1'b1, 32'h0,    32'h5C,  32'h12345678, 32'h0,         4'd0, 4'd0, 4'd7}, // R7 store hit
    '{2'd0, 1'b1, 32'h0,    32'h5C,  32'h0,        32'h12345678,  4'd0, 4'd0, 4'd7}, // R7
    '{2'd0, 1'b1, 32'h0,    32'h40,  32'h0,        32'h0,         4'd0, 4'd0, 4'd2}  // R2 first word
  };

  initial begin
    logic [31:0] rd;
    int nrd, nwr;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R9 ready", {31'b0, req_ready}, 32'd1);
    check("R9 resp_valid", {31'b0, resp_valid}, 32'd0);
    check("R9 mem_req", {31'b0, mem_req}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
      run_op(VEC[i].op, VEC[i].raz, VEC[i].ra, VEC[i].rb, VEC[i].wd, rd, nrd, nwr);
      if (VEC[i].op == 2'd0 || VEC[i].op == 2'd3) check({tag, " rdata"}, rd, VEC[i].exp);
      check({tag, " reads"}, nrd, {28'b0, VEC[i].nrd});
      check({tag, " writes"}, nwr, {28'b0, VEC[i].nwr});
    end

    // R8: single-cycle completion pulse
    @(negedge clk);
    check("R8 resp pulse", {31'b0, resp_valid}, 32'd0);
    check("R8 ready low while busy", busy_viol, 0);
    // R10: request held steady until acknowledged
    check("R10 mem hold", hold_viol, 0);

    // R9: reset invalidates all lines (line 2 held a dirty zero line)
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 ready in reset", {31'b0, req_ready}, 32'd1);
    rst_n = 1'b1;
    run_op(2'd0, 1'b1, 32'h0, 32'h48, 32'h0, rd, nrd, nwr);
    check("R9 miss after reset rdata", rd, 32'hA500_0202);
    check("R9 miss after reset reads", nrd, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule